// File: doc/BRIEF.md
# Raster sync generator with half-line interlace

This block produces horizontal and vertical sync for a raster display, clocked by the video pixel-group clock. A horizontal counter runs up to its all-ones value. On that final count it raises a one-cycle reload pulse, and on the next edge it jumps to a restart value that depends on the selected refresh rate. A line counter advances on every reload. At the end of each field it clears and toggles a field parity flag.

The block can make the display interlace. When the parity flag is about to fall, it sends an interlace request into the reload. The first line of that field then restarts with the counter's top bit set. That line is about half as long, so the field is offset by half a line. The request is honoured only in low-resolution mode, only when interlace is enabled and only with internal sync. A build parameter can delay the request by one cycle, so that it misses the reload and the output never interlaces.

When external sync is selected, the sync outputs follow the external inputs and the internal counters do not affect them.

Top module: `vsg_sync_gen`

## Requirements
- R1: With internal sync, each full line is LEN50=128 clocks for rate code 0 (and code 3), LEN60=127 for code 1 and LEN70=56 for code 2. The restart value is 128 minus the length on the 7-bit counter.
- R2: hsync is high for exactly HS_LEN=8 clocks per line: the final 8 counts before the reload. It falls in the same cycle that line_start rises.
- R3: A field has LINES50/LINES60/LINES70 lines, chosen by rate code. field toggles only in the first cycle of a field's first line. vsync is high for the first VS_LINES=3 lines of each field.
- R4: line_start is high for exactly one cycle, the first cycle of every line, and never for two cycles in a row.
- R5: With lowres=1, ilace_en=1 and ext_sel=0, the first line of every field whose parity is 0 restarts from its restart value with bit 6 set. That line is half length: 64 clocks at 50 Hz and 63 at 60 Hz. All other lines are full.
- R6: With ilace_en=0, no line is shortened.
- R7: With lowres=0, no line is shortened and every reload takes the plain rate restart value.
- R8: With ext_sel=1, hsync and vsync follow ext_hsync and ext_vsync. line_start pulses on the cycle after ext_hsync is first sampled high. ilace_en has no effect on the line spacing.
- R9: With LATE_REQ=1, the interlace request arrives one cycle after the reload pulse, and no line is ever shortened.
- R10: While rst_n is low: hsync=0, vsync=1, field=0, line_start=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Refresh rate: 0=50 Hz, 1=60 Hz, 2=70 Hz, 3=50 Hz |
| lowres | input | 1 | Low-resolution mode; interlace is allowed only here |
| ilace_en | input | 1 | Interlace enable |
| ext_sel | input | 1 | Use external sync instead of the internal counters |
| ext_hsync | input | 1 | External horizontal sync |
| ext_vsync | input | 1 | External vertical sync |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| field | output | 1 | Current field parity |
| line_start | output | 1 | One-cycle strobe in the first cycle of each line |

## Verification
Each configuration runs at least four whole fields, and the bench measures every line's length, sync width, lines per field and field position.

- Interlace on at 50 Hz and 60 Hz must give exactly two half lines. Each must be the first line of a parity-0 field.
- Interlace off, high resolution and external sync give the same line pattern with the request gated away. Any shortened line separates these three gating paths from a working one.
- The late-request build, run in the enabling configuration, must give no half lines. This tells the one-cycle timing miss apart from a gating fault.
- The 70 Hz run covers the short line and the long field.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  typedef enum logic [1:0] {
    RATE_50  = 2'd0,
    RATE_60  = 2'd1,
    RATE_70  = 2'd2,
    RATE_ALT = 2'd3
  } rate_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/vsg_hcount.sv
// Horizontal counter: runs up to all-ones, then reloads from the restart value,
// optionally with the top bit forced (half-length line).
module vsg_hcount #(
  parameter int HW     = 7,
  parameter int HS_LEN = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] restart,
  input  logic          mid_req,
  output logic [HW-1:0] hcnt,
  output logic          reload,
  output logic          hsync,
  output logic          line_start
);
  localparam logic [HW-1:0] MAXV       = '1;
  localparam logic [HW-1:0] MID        = {1'b1, {(HW-1){1'b0}}};
  localparam int            HS_FIRST_I = (2 ** HW) - HS_LEN;
  localparam logic [HW-1:0] HS_FIRST   = HS_FIRST_I[HW-1:0];

  assign reload = (hcnt == MAXV);
  assign hsync  = (hcnt >= HS_FIRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt       <= '0;
      line_start <= 1'b0;
    end else begin
      line_start <= reload;
      if (reload) hcnt <= restart | (mid_req ? MID : '0);
      else        hcnt <= hcnt + 1'b1;
    end
  end
endmodule

// File: rtl/vsg_vcount.sv
// Line counter, field parity and interlace request timing.
module vsg_vcount #(
  parameter int VW       = 9,
  parameter int VS_LINES = 3,
  parameter bit LATE_REQ = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic [VW-1:0] last_line,
  input  logic          ilace_ok,
  output logic [VW-1:0] vcnt,
  output logic          vsync,
  output logic          parity,
  output logic          ilace_req
);
  localparam logic [VW-1:0] VS_END = VS_LINES[VW-1:0];

  logic field_end;
  assign field_end = reload && (vcnt >= last_line);
  assign vsync     = (vcnt < VS_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt   <= '0;
      parity <= 1'b0;
    end else if (reload) begin
      vcnt <= field_end ? '0 : vcnt + 1'b1;
      if (field_end) parity <= ~parity;
    end
  end

  generate
    if (LATE_REQ) begin : g_late
      // Trailing copy of the parity; the request shows up one cycle after the reload.
      logic parity_d;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) parity_d <= 1'b0;
        else        parity_d <= parity;
      end
      assign ilace_req = ilace_ok && !parity && parity_d;
    end else begin : g_ontime
      // Parity is about to fall on this reload: request lands on the reload cycle.
      assign ilace_req = ilace_ok && field_end && parity;
    end
  endgenerate
endmodule

// File: rtl/vsg_sync_gen.sv
module vsg_sync_gen
  import vsg_pkg::*;
#(
  parameter int HW       = 7,
  parameter int HS_LEN   = 8,
  parameter int LEN50    = 128,
  parameter int LEN60    = 127,
  parameter int LEN70    = 56,
  parameter int LINES50  = 313,
  parameter int LINES60  = 263,
  parameter int LINES70  = 501,
  parameter int VS_LINES = 3,
  parameter bit LATE_REQ = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  input  logic       lowres,
  input  logic       ilace_en,
  input  logic       ext_sel,
  input  logic       ext_hsync,
  input  logic       ext_vsync,
  output logic       hsync,
  output logic       vsync,
  output logic       field,
  output logic       line_start
);
  localparam int VW     = $clog2(max3(LINES50, LINES60, LINES70));
  localparam int RS50_I = (2 ** HW) - LEN50;
  localparam int RS60_I = (2 ** HW) - LEN60;
  localparam int RS70_I = (2 ** HW) - LEN70;
  localparam int LL50_I = LINES50 - 1;
  localparam int LL60_I = LINES60 - 1;
  localparam int LL70_I = LINES70 - 1;

  rate_e         rate;
  logic [HW-1:0] restart;
  logic [VW-1:0] last_line;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          reload, int_hs, int_ls, int_vs, parity, ilace_req, ilace_ok;
  logic          ext_h_q, ext_ls;

  assign rate = rate_e'(rate_sel);

  always_comb begin
    case (rate)
      RATE_60: begin restart = RS60_I[HW-1:0]; last_line = LL60_I[VW-1:0]; end
      RATE_70: begin restart = RS70_I[HW-1:0]; last_line = LL70_I[VW-1:0]; end
      default: begin restart = RS50_I[HW-1:0]; last_line = LL50_I[VW-1:0]; end
    endcase
  end

  assign ilace_ok = lowres && ilace_en && !ext_sel;

  vsg_hcount #(.HW(HW), .HS_LEN(HS_LEN)) u_h (
    .clk(clk), .rst_n(rst_n), .restart(restart), .mid_req(ilace_req),
    .hcnt(hcnt), .reload(reload), .hsync(int_hs), .line_start(int_ls)
  );

  vsg_vcount #(.VW(VW), .VS_LINES(VS_LINES), .LATE_REQ(LATE_REQ)) u_v (
    .clk(clk), .rst_n(rst_n), .reload(reload), .last_line(last_line),
    .ilace_ok(ilace_ok), .vcnt(vcnt), .vsync(int_vs), .parity(parity),
    .ilace_req(ilace_req)
  );

  // External sync: line strobe from the registered rising edge of ext_hsync.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_h_q <= 1'b0;
      ext_ls  <= 1'b0;
    end else begin
      ext_h_q <= ext_hsync;
      ext_ls  <= ext_hsync && !ext_h_q;
    end
  end

  assign hsync      = ext_sel ? ext_hsync : int_hs;
  assign vsync      = ext_sel ? ext_vsync : int_vs;
  assign line_start = ext_sel ? ext_ls    : int_ls;
  assign field      = parity;
endmodule

// File: rtl/vsg_sync_gen_chk.sv
module vsg_sync_gen_chk #(
  parameter int HW       = 7,
  parameter bit LATE_REQ = 1'b0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ext_sel,
  input logic          lowres,
  input logic          ext_hsync,
  input logic          hsync,
  input logic          field,
  input logic          line_start,
  input logic          reload,
  input logic          ilace_req,
  input logic [HW-1:0] hcnt,
  input logic [HW-1:0] restart
);
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !line_start);

  a_r2_hsync_ends_line: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sel && !$past(ext_sel) && $fell(hsync)) |-> line_start);

  a_r3_field_at_line_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sel && !$past(ext_sel) && (field != $past(field))) |-> line_start);

  a_r8_ext_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel && $rose(ext_hsync)) |=> (line_start || !ext_sel));

  a_r7_hires_plain_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (!lowres && reload) |=> (hcnt == $past(restart)));

  generate
    if (LATE_REQ) begin : g_late
      a_r9_late_never_mid: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (hcnt == $past(restart)));
    end else begin : g_ontime
      a_r5_mid_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && ilace_req) |=> hcnt[HW-1]);
      a_r6_plain_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !ilace_req) |=> (hcnt == $past(restart)));
    end
  endgenerate
endmodule

bind vsg_sync_gen vsg_sync_gen_chk #(.HW(HW), .LATE_REQ(LATE_REQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .lowres(lowres),
  .ext_hsync(ext_hsync), .hsync(hsync), .field(field), .line_start(line_start),
  .reload(reload), .ilace_req(ilace_req), .hcnt(hcnt), .restart(restart)
);

// File: tb/vsg_sync_gen_test.sv
module vsg_sync_gen_test;
  localparam int L50 = 9, L60 = 7, L70 = 11, HSL = 8, VSL = 3, EXT_P = 40;

  typedef struct packed {
    logic [1:0] rate;
    logic       lowres, ilace, ext, late;
    int         full_len, half_len, lpf, halves, nfields;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 128, 64, L50, 2, 4},
    '{2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 127, 63, L60, 2, 4},
    '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 128,  0, L50, 0, 4},
    '{2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 128,  0, L50, 0, 4},
    '{2'd2, 1'b0, 1'b1, 1'b0, 1'b0,  56,  0, L70, 0, 4},
    '{2'd0, 1'b1, 1'b1, 1'b1, 1'b0, EXT_P, 0,  0, 0, 0},
    '{2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 128,  0, L50, 0, 4},
    '{2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 127,  0, L60, 0, 4}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic lowres = 1'b0, ilace_en = 1'b0, ext_sel = 1'b0, ext_hsync = 1'b0, ext_vsync = 1'b0;
  logic obs_late = 1'b0;
  logic hs_u, vs_u, fd_u, ls_u, hs_l, vs_l, fd_l, ls_l;
  logic o_hs, o_vs, o_fd, o_ls;
  int n_run = 0, n_fail = 0;

  initial forever #5 clk = ~clk;

  vsg_sync_gen #(.LINES50(L50), .LINES60(L60), .LINES70(L70), .LATE_REQ(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .lowres(lowres), .ilace_en(ilace_en),
    .ext_sel(ext_sel), .ext_hsync(ext_hsync), .ext_vsync(ext_vsync),
    .hsync(hs_u), .vsync(vs_u), .field(fd_u), .line_start(ls_u));

  vsg_sync_gen #(.LINES50(L50), .LINES60(L60), .LINES70(L70), .LATE_REQ(1'b1)) uut_late (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .lowres(lowres), .ilace_en(ilace_en),
    .ext_sel(ext_sel), .ext_hsync(ext_hsync), .ext_vsync(ext_vsync),
    .hsync(hs_l), .vsync(vs_l), .field(fd_l), .line_start(ls_l));

  assign o_hs = obs_late ? hs_l : hs_u;
  assign o_vs = obs_late ? vs_l : vs_u;
  assign o_fd = obs_late ? fd_l : fd_u;
  assign o_ls = obs_late ? ls_l : ls_u;

  // External sync source: period EXT_P, high for the last HSL clocks.
  initial begin
    int g = 0;
    forever begin
      @(negedge clk);
      g = (g + 1) % EXT_P;
      ext_hsync = (g >= EXT_P - HSL);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string vtag(input int i);
    case (i)
      0, 1:    return "R5";
      2:       return "R6";
      3:       return "R7";
      4:       return "R1";
      5:       return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic run_vec(input int i);
    vec_t v;
    int len, hs, fields, lif, vsl, lines;
    int bad_len, halves, bad_pos, hs_bad, fld_bad, ls_bad;
    bit started, cur_first, cur_par, prev_par, prev_ls, done;
    v = VEC[i];
    len = 0; hs = 0; fields = 0; lif = 0; vsl = 0; lines = 0;
    bad_len = 0; halves = 0; bad_pos = 0; hs_bad = 0; fld_bad = 0; ls_bad = 0;
    started = 0; cur_first = 0; cur_par = 0; prev_ls = 0; done = 0;
    @(negedge clk);
    rst_n = 1'b0;
    rate_sel = v.rate; lowres = v.lowres; ilace_en = v.ilace; ext_sel = v.ext; obs_late = v.late;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    prev_par = o_fd;
    while (!done) begin
      @(negedge clk);
      if (o_ls && prev_ls) ls_bad++;
      prev_ls = o_ls;
      if (o_ls) begin
        if (started) begin
          if (len == v.full_len) begin
          end else if (v.half_len != 0 && len == v.half_len) begin
            halves++;
            if (!(cur_first && !cur_par)) bad_pos++;
          end else bad_len++;
          if (hs != HSL) hs_bad++;
          lines++;
        end
        started = 1; len = 0; hs = 0;
        cur_par = o_fd; cur_first = (o_fd != prev_par); prev_par = o_fd;
        if (v.nfields != 0 && cur_first) begin
          if (fields > 0 && (lif != v.lpf || vsl != VSL)) fld_bad++;
          fields++; lif = 0; vsl = 0;
          if (fields > v.nfields) done = 1;
        end
        lif++;
        if (o_vs) vsl++;
        if (v.nfields == 0 && lines >= 30) done = 1;
      end
      if (started) begin
        len++;
        if (o_hs) hs++;
      end
    end
    chk(bad_len == 0, (i == 4) ? "R1" : vtag(i), bad_len, 0); // R1 line lengths
    chk(halves == v.halves, vtag(i), halves, v.halves);
    if (v.half_len != 0) chk(bad_pos == 0, "R5", bad_pos, 0);
    chk(hs_bad == 0, "R2", hs_bad, 0);
    if (v.nfields != 0) chk(fld_bad == 0, "R3", fld_bad, 0);
    chk(ls_bad == 0 && lines > 0, "R4", ls_bad, 0);
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk(o_hs == 1'b0, "R10", int'(o_hs), 0);
    chk(o_vs == 1'b1, "R10", int'(o_vs), 1);
    chk(o_fd == 1'b0, "R10", int'(o_fd), 0);
    chk(o_ls == 1'b0, "R10", int'(o_ls), 0);

    for (int i = 0; i < 8; i++) run_vec(i);

    // R8: external vsync pass-through
    ext_sel = 1'b1; obs_late = 1'b0;
    ext_vsync = 1'b1;
    @(negedge clk);
    chk(o_vs == 1'b1, "R8", int'(o_vs), 1);
    ext_vsync = 1'b0;
    @(negedge clk);
    chk(o_vs == 1'b0, "R8", int'(o_vs), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule